// File: doc/BRIEF.md
# Divergent split FIFO scheduler

This block keeps, for one warp, the set of divergent thread splits and the order in which they are served. Each split is stored in a table slot selected by its split ID and holds a program counter, a reconvergence program counter, an active-lane mask and three flags: valid, blocked and virtual. A separate order queue lists the IDs of the live splits. The first queue position is the split the warp normally runs. The second position is offered to the issue logic as a co-issue candidate.

Splits come in through a push port. Each accepted push writes the table slot and appends the ID at the tail of the queue. A scheduler can move any queued split to the head in a single cycle. That split then becomes the active one, and every other entry keeps its relative order. The scheduler can also overwrite the program counter of a live split by ID, and look up any ID to see whether it is valid and what it holds. Creating splits at branches and merging them at reconvergence are handled elsewhere.

Split IDs are one bit wider than the table index needs, so the all-ones code is never a real slot and means "no split".

Top module: `divergent_split_sched`

## Requirements
- R1: After reset the queue is empty. `q_count` is 0, every slot of `q_order` and `active_id` hold the all-ones code, and `sec_present`, `mv_done` and `upd_err` are 0.
- R2: A push is accepted only when all three of these hold: the ID is below `NUM_SPLITS`, its table slot is not valid, and the queue is not full. An accepted push marks the slot valid with the given fields and appends the ID at the tail, so `q_count` rises by one. A rejected push changes neither the queue nor the table.
- R3: `sec_present` is 1 exactly when `q_count` is at least 2. `sec_id` always equals queue position 1, and that position holds the all-ones code when unused.
- R4: `sec_ok` is 1 only when the secondary split is present and its slot is valid, not blocked and not virtual. In that case `sec_pc`, `sec_rpc` and `sec_mask` show that slot's fields. Otherwise these three outputs are zero.
- R5: A move request that targets the ID already at queue position 0 leaves the order unchanged. One cycle later `mv_done` and `mv_ok` are 1 and `active_id` equals the ID.
- R6: A move request that targets an ID at queue position p > 0 puts that ID at position 0 and shifts positions 0..p-1 down by one. Positions above p are unchanged. One cycle later `mv_ok` is 1 and `active_id` equals the ID.
- R7: A move request on an empty queue, or for an ID not in the queue, gives `mv_done`=1 and `mv_ok`=0 one cycle later, and leaves the order and `active_id` unchanged.
- R8: A program-counter update on a valid split replaces that split's PC from the next cycle on. An update on an ID whose slot is not valid changes nothing and raises `upd_err` for one cycle.
- R9: The lookup port reports, in the same cycle, `look_valid` for `look_id`. When the slot is valid it also reports its PC and mask; when it is not, both are zero.
- R10: When a push and a move arrive in the same cycle, the move acts on the queue as it stood before that cycle, and the accepted push is then appended at the new tail. A move that names the ID being pushed in that same cycle fails.
- R11: `q_order` packs queue position k into bits [k*ID_W +: ID_W], where ID_W is the split ID width (4 by default). Slots beyond `q_count` hold all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Push request |
| push_id | input | ID_W | Split ID to load |
| push_pc | input | PC_W | PC of the new split |
| push_rpc | input | PC_W | Reconvergence PC of the new split |
| push_mask | input | LANES | Active-lane mask of the new split |
| push_blocked | input | 1 | Blocked flag of the new split |
| push_virtual | input | 1 | Virtual flag of the new split |
| mv_en | input | 1 | Move-to-front request |
| mv_id | input | ID_W | Split ID to move |
| upd_en | input | 1 | PC update request |
| upd_id | input | ID_W | Split ID whose PC is rewritten |
| upd_pc | input | PC_W | New PC |
| look_id | input | ID_W | Split ID to look up |
| look_valid | output | 1 | Looked-up slot is valid |
| look_pc | output | PC_W | PC of the looked-up slot |
| look_mask | output | LANES | Mask of the looked-up slot |
| sec_present | output | 1 | Queue holds at least two entries |
| sec_ok | output | 1 | Secondary split is usable for co-issue |
| sec_id | output | ID_W | ID at queue position 1 |
| sec_pc | output | PC_W | Secondary split PC |
| sec_rpc | output | PC_W | Secondary split reconvergence PC |
| sec_mask | output | LANES | Secondary split mask |
| mv_done | output | 1 | A move was requested in the previous cycle |
| mv_ok | output | 1 | That move succeeded |
| active_id | output | ID_W | Split most recently made active |
| upd_err | output | 1 | PC update hit an invalid split in the previous cycle |
| q_count | output | CNT_W | Number of queued splits |
| q_order | output | NUM_SPLITS*ID_W | Queue order, position 0 in the low bits |

## Verification
A push and a move-to-front can land in the same cycle. The move must then use the queue as it stood before that cycle, and the new ID must land behind the reordered entries. The bench provokes this in directed steps, one of which names the just-pushed ID as the move target, and again in random sequences where both requests are drawn independently each cycle. A reference model applies the move first and the append second. Every resulting order, count, move result and secondary view is compared against that model in the cycle after the request.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  localparam int DEF_SPLITS = 8;
  localparam int DEF_PC_W   = 32;
  localparam int DEF_LANES  = 32;

  // per-slot state bits of one divergent split
  typedef struct packed {
    logic valid;
    logic blocked;
    logic virt;
  } split_flags_t;

  // one spare code above the table range serves as "no split"
  function automatic int split_id_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dsq_split_table.sv
module dsq_split_table
  import dsq_pkg::*;
#(
  parameter int N     = DEF_SPLITS,
  parameter int PC_W  = DEF_PC_W,
  parameter int LANES = DEF_LANES,
  parameter int ID_W  = split_id_width(DEF_SPLITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ID_W-1:0]    wr_id,
  input  logic [PC_W-1:0]    wr_pc,
  input  logic [PC_W-1:0]    wr_rpc,
  input  logic [LANES-1:0]   wr_mask,
  input  logic               wr_blk,
  input  logic               wr_virt,
  input  logic               upd_en,
  input  logic [ID_W-1:0]    upd_id,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic [ID_W-1:0]    ra_id,
  input  logic [ID_W-1:0]    rb_id,
  output logic               wr_free,
  output logic               upd_hit,
  output split_flags_t       ra_flags,
  output logic [PC_W-1:0]    ra_pc,
  output logic [PC_W-1:0]    ra_rpc,
  output logic [LANES-1:0]   ra_mask,
  output logic               rb_valid,
  output logic [PC_W-1:0]    rb_pc,
  output logic [LANES-1:0]   rb_mask
);

  split_flags_t     flg_q [N];
  split_flags_t     flg_d [N];
  logic [PC_W-1:0]  pc_q  [N];
  logic [PC_W-1:0]  pc_d  [N];
  logic [PC_W-1:0]  rpc_q [N];
  logic [PC_W-1:0]  rpc_d [N];
  logic [LANES-1:0] msk_q [N];
  logic [LANES-1:0] msk_d [N];
  logic [N-1:0]     wsel;
  logic [N-1:0]     usel;
  logic [N-1:0]     slot_en;
  logic [N-1:0]     vvec;

  // next-state: a load needs a free slot, an update needs a live one
  always_comb begin
    for (int i = 0; i < N; i++) begin
      wsel[i]    = wr_en  && (wr_id  == ID_W'(i)) && !flg_q[i].valid;
      usel[i]    = upd_en && (upd_id == ID_W'(i)) &&  flg_q[i].valid;
      slot_en[i] = wsel[i] | usel[i];
      flg_d[i]   = flg_q[i];
      pc_d[i]    = pc_q[i];
      rpc_d[i]   = rpc_q[i];
      msk_d[i]   = msk_q[i];
      if (wsel[i]) begin
        flg_d[i] = '{valid: 1'b1, blocked: wr_blk, virt: wr_virt};
        pc_d[i]  = wr_pc;
        rpc_d[i] = wr_rpc;
        msk_d[i] = wr_mask;
      end
      if (usel[i]) begin
        pc_d[i] = upd_pc;
      end
      vvec[i] = flg_q[i].valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        flg_q[i] <= '0;
        pc_q[i]  <= '0;
        rpc_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (slot_en[i]) begin
          flg_q[i] <= flg_d[i];
          pc_q[i]  <= pc_d[i];
          rpc_q[i] <= rpc_d[i];
          msk_q[i] <= msk_d[i];
        end
      end
    end
  end

  // read ports and slot status, decoded by ID compare
  always_comb begin
    wr_free  = 1'b0;
    upd_hit  = 1'b0;
    ra_flags = '0;
    ra_pc    = '0;
    ra_rpc   = '0;
    ra_mask  = '0;
    rb_valid = 1'b0;
    rb_pc    = '0;
    rb_mask  = '0;
    for (int i = 0; i < N; i++) begin
      if (wr_id == ID_W'(i))  wr_free = !flg_q[i].valid;
      if (upd_id == ID_W'(i)) upd_hit = flg_q[i].valid;
      if (ra_id == ID_W'(i)) begin
        ra_flags = flg_q[i];
        ra_pc    = pc_q[i];
        ra_rpc   = rpc_q[i];
        ra_mask  = msk_q[i];
      end
      if (rb_id == ID_W'(i) && flg_q[i].valid) begin
        rb_valid = 1'b1;
        rb_pc    = pc_q[i];
        rb_mask  = msk_q[i];
      end
    end
  end

  // R2
  valid_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vvec) >= $countones($past(vvec)));

  // R8
  upd_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_hit && !wr_en) |=> (vvec == $past(vvec)));

endmodule

// File: rtl/dsq_split_order.sv
module dsq_split_order
  import dsq_pkg::*;
#(
  parameter int N     = DEF_SPLITS,
  parameter int ID_W  = split_id_width(DEF_SPLITS),
  parameter int CNT_W = $clog2(DEF_SPLITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [ID_W-1:0]   push_id,
  input  logic              mv_en,
  input  logic [ID_W-1:0]   mv_id,
  output logic [N*ID_W-1:0] order_flat,
  output logic [CNT_W-1:0]  cnt,
  output logic              mv_hit,
  output logic              mv_done,
  output logic              mv_ok,
  output logic [ID_W-1:0]   active_id
);

  logic [ID_W-1:0]  slot_q  [N];
  logic [ID_W-1:0]  slot_d  [N];
  logic [ID_W-1:0]  shifted [N];
  logic [N-1:0]     match;
  logic [N-1:0]     tail_or;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             slots_en;
  logic             done_q, ok_q;
  logic [ID_W-1:0]  act_q, act_d;

  // one comparator per queue position, live positions only
  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = mv_en && (CNT_W'(g) < cnt_q) && (slot_q[g] == mv_id);
  end

  assign mv_hit = |match;

  // shift network: position i moves down when the target sits at or above i
  always_comb begin
    tail_or[N-1] = match[N-1];
    for (int i = N - 2; i >= 0; i--) begin
      tail_or[i] = match[i] | tail_or[i+1];
    end
    for (int i = 0; i < N; i++) begin
      if (i == 0) begin
        shifted[i] = mv_hit ? mv_id : slot_q[i];
      end else begin
        shifted[i] = tail_or[i] ? slot_q[i-1] : slot_q[i];
      end
      slot_d[i] = (push_en && (cnt_q == CNT_W'(i))) ? push_id : shifted[i];
    end
    cnt_d    = cnt_q + CNT_W'(push_en);
    slots_en = push_en | mv_hit;
    act_d    = mv_hit ? mv_id : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) slot_q[i] <= '1;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      act_q  <= '1;
    end else begin
      if (slots_en) begin
        for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
      end
      if (push_en) cnt_q <= cnt_d;
      done_q <= mv_en;
      ok_q   <= mv_hit;
      act_q  <= act_d;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) order_flat[i*ID_W +: ID_W] = slot_q[i];
  end

  assign cnt       = cnt_q;
  assign mv_done   = done_q;
  assign mv_ok     = ok_q;
  assign active_id = act_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(N));

  // R6
  mv_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_hit |=> (slot_q[0] == $past(mv_id)));

  // R7
  mv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_en && !mv_hit && !push_en) |=> ($stable(order_flat) && $stable(active_id)));

  // R5
  mv_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_hit && (slot_q[0] == mv_id) && !push_en) |=> $stable(order_flat));

  // R7
  mv_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_ok |-> mv_done);

endmodule

// File: rtl/dsq_sec_query.sv
module dsq_sec_query
  import dsq_pkg::*;
#(
  parameter int PC_W  = DEF_PC_W,
  parameter int LANES = DEF_LANES,
  parameter int ID_W  = split_id_width(DEF_SPLITS),
  parameter int CNT_W = $clog2(DEF_SPLITS + 1)
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [ID_W-1:0]  slot1_id,
  input  split_flags_t     flags,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  rpc,
  input  logic [LANES-1:0] mask,
  output logic             sec_present,
  output logic             sec_ok,
  output logic [ID_W-1:0]  sec_id,
  output logic [PC_W-1:0]  sec_pc,
  output logic [PC_W-1:0]  sec_rpc,
  output logic [LANES-1:0] sec_mask
);

  // a candidate is usable only when it is live and neither parked nor virtual
  always_comb begin
    sec_present = (cnt >= CNT_W'(2));
    sec_id      = sec_present ? slot1_id : '1;
    sec_ok      = sec_present && flags.valid && !flags.blocked && !flags.virt;
    sec_pc      = sec_ok ? pc   : '0;
    sec_rpc     = sec_ok ? rpc  : '0;
    sec_mask    = sec_ok ? mask : '0;
  end

endmodule

// File: rtl/divergent_split_sched.sv
module divergent_split_sched
  import dsq_pkg::*;
#(
  parameter int NUM_SPLITS = DEF_SPLITS,
  parameter int PC_W       = DEF_PC_W,
  parameter int LANES      = DEF_LANES,
  localparam int ID_W      = split_id_width(NUM_SPLITS),
  localparam int CNT_W     = $clog2(NUM_SPLITS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_en,
  input  logic [ID_W-1:0]            push_id,
  input  logic [PC_W-1:0]            push_pc,
  input  logic [PC_W-1:0]            push_rpc,
  input  logic [LANES-1:0]           push_mask,
  input  logic                       push_blocked,
  input  logic                       push_virtual,
  input  logic                       mv_en,
  input  logic [ID_W-1:0]            mv_id,
  input  logic                       upd_en,
  input  logic [ID_W-1:0]            upd_id,
  input  logic [PC_W-1:0]            upd_pc,
  input  logic [ID_W-1:0]            look_id,
  output logic                       look_valid,
  output logic [PC_W-1:0]            look_pc,
  output logic [LANES-1:0]           look_mask,
  output logic                       sec_present,
  output logic                       sec_ok,
  output logic [ID_W-1:0]            sec_id,
  output logic [PC_W-1:0]            sec_pc,
  output logic [PC_W-1:0]            sec_rpc,
  output logic [LANES-1:0]           sec_mask,
  output logic                       mv_done,
  output logic                       mv_ok,
  output logic [ID_W-1:0]            active_id,
  output logic                       upd_err,
  output logic [CNT_W-1:0]           q_count,
  output logic [NUM_SPLITS*ID_W-1:0] q_order
);

  logic             wr_free, upd_hit, push_acc, mv_hit;
  logic             err_d, err_q;
  split_flags_t     sec_flags;
  logic [PC_W-1:0]  sec_raw_pc, sec_raw_rpc;
  logic [LANES-1:0] sec_raw_mask;
  logic [ID_W-1:0]  slot1_id;

  assign push_acc = push_en && wr_free && (q_count < CNT_W'(NUM_SPLITS));
  assign slot1_id = q_order[ID_W +: ID_W];

  dsq_split_table #(
    .N(NUM_SPLITS), .PC_W(PC_W), .LANES(LANES), .ID_W(ID_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_acc), .wr_id(push_id), .wr_pc(push_pc), .wr_rpc(push_rpc),
    .wr_mask(push_mask), .wr_blk(push_blocked), .wr_virt(push_virtual),
    .upd_en(upd_en), .upd_id(upd_id), .upd_pc(upd_pc),
    .ra_id(slot1_id), .rb_id(look_id),
    .wr_free(wr_free), .upd_hit(upd_hit),
    .ra_flags(sec_flags), .ra_pc(sec_raw_pc), .ra_rpc(sec_raw_rpc),
    .ra_mask(sec_raw_mask),
    .rb_valid(look_valid), .rb_pc(look_pc), .rb_mask(look_mask)
  );

  dsq_split_order #(
    .N(NUM_SPLITS), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_order (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_acc), .push_id(push_id),
    .mv_en(mv_en), .mv_id(mv_id),
    .order_flat(q_order), .cnt(q_count), .mv_hit(mv_hit),
    .mv_done(mv_done), .mv_ok(mv_ok), .active_id(active_id)
  );

  dsq_sec_query #(
    .PC_W(PC_W), .LANES(LANES), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_query (
    .cnt(q_count), .slot1_id(slot1_id), .flags(sec_flags),
    .pc(sec_raw_pc), .rpc(sec_raw_rpc), .mask(sec_raw_mask),
    .sec_present(sec_present), .sec_ok(sec_ok), .sec_id(sec_id),
    .sec_pc(sec_pc), .sec_rpc(sec_rpc), .sec_mask(sec_mask)
  );

  always_comb err_d = upd_en && !upd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign upd_err = err_q;

  // R8
  upd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (upd_id == look_id) && !look_valid) |=> upd_err);

  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_en && push_acc && (mv_id == push_id)) |=> !mv_ok);

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> (q_count == $past(q_count) + CNT_W'(1)));

  // R3
  sec_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && (q_count == CNT_W'(1))) |=> sec_present);

endmodule

// File: tb/sim_divergent_split_sched.sv
`timescale 1ns/1ps
module sim_divergent_split_sched;
  localparam int N    = 8;
  localparam int IDW  = 4;
  localparam int CW   = 4;
  localparam int NONE = 15;

  logic clk, rst_n;
  logic push_en, push_blocked, push_virtual, mv_en, upd_en;
  logic [IDW-1:0] push_id, mv_id, upd_id, look_id;
  logic [31:0] push_pc, push_rpc, push_mask, upd_pc;
  logic look_valid, sec_present, sec_ok, mv_done, mv_ok, upd_err;
  logic [31:0] look_pc, look_mask, sec_pc, sec_rpc, sec_mask;
  logic [IDW-1:0] sec_id, active_id;
  logic [CW-1:0] q_count;
  logic [N*IDW-1:0] q_order;

  divergent_split_sched u0 (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_id(push_id),
    .push_pc(push_pc), .push_rpc(push_rpc), .push_mask(push_mask),
    .push_blocked(push_blocked), .push_virtual(push_virtual),
    .mv_en(mv_en), .mv_id(mv_id), .upd_en(upd_en), .upd_id(upd_id),
    .upd_pc(upd_pc), .look_id(look_id), .look_valid(look_valid),
    .look_pc(look_pc), .look_mask(look_mask), .sec_present(sec_present),
    .sec_ok(sec_ok), .sec_id(sec_id), .sec_pc(sec_pc), .sec_rpc(sec_rpc),
    .sec_mask(sec_mask), .mv_done(mv_done), .mv_ok(mv_ok),
    .active_id(active_id), .upd_err(upd_err), .q_count(q_count),
    .q_order(q_order)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model
  int          m_q [N];
  int          m_cnt, m_act;
  bit          m_v [N];
  bit          m_b [N];
  bit          m_x [N];
  logic [31:0] m_pc [N];
  logic [31:0] m_rpc [N];
  logic [31:0] m_mask [N];

  typedef struct {
    int cnt; logic [N*IDW-1:0] ord; bit sp; bit sok; int sid;
    logic [31:0] spc; logic [31:0] srpc; logic [31:0] smask;
    bit mvd; bit mvok; int act; bit uerr;
    bit lv; logic [31:0] lpc; logic [31:0] lmask;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  task automatic chk(input string req, input string what,
                     input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_q[i] = NONE; m_v[i] = 0; m_b[i] = 0; m_x[i] = 0;
      m_pc[i] = 0; m_rpc[i] = 0; m_mask[i] = 0;
    end
    m_cnt = 0; m_act = NONE;
  endtask

  task automatic drive_idle();
    push_en = 0; push_id = 0; push_pc = 0; push_rpc = 0; push_mask = 0;
    push_blocked = 0; push_virtual = 0; mv_en = 0; mv_id = 0;
    upd_en = 0; upd_id = 0; upd_pc = 0; look_id = 0;
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input bit pe, input int pid, input logic [31:0] ppc,
                      input logic [31:0] prpc, input logic [31:0] pmask,
                      input bit pb, input bit px, input bit me, input int mid,
                      input bit ue, input int uid, input logic [31:0] upc,
                      input int lid, input string tag);
    exp_t e;
    bit pacc, hit, uerr;
    int pos;
    @(negedge clk);
    push_en = pe; push_id = pid[IDW-1:0]; push_pc = ppc; push_rpc = prpc;
    push_mask = pmask; push_blocked = pb; push_virtual = px;
    mv_en = me; mv_id = mid[IDW-1:0];
    upd_en = ue; upd_id = uid[IDW-1:0]; upd_pc = upc; look_id = lid[IDW-1:0];
    pacc = pe && (pid < N) && (m_cnt < N);
    if (pacc) pacc = !m_v[pid];
    uerr = ue && !((uid < N) && m_v[uid < N ? uid : 0]);
    hit = 0; pos = 0;
    if (me) for (int i = 0; i < m_cnt; i++) if (m_q[i] == mid && !hit) begin hit = 1; pos = i; end
    if (hit) begin
      for (int i = pos; i > 0; i--) m_q[i] = m_q[i-1];
      m_q[0] = mid; m_act = mid;
    end
    if (ue && !uerr) m_pc[uid] = upc;
    if (pacc) begin
      m_q[m_cnt] = pid; m_cnt++;
      m_v[pid] = 1; m_b[pid] = pb; m_x[pid] = px;
      m_pc[pid] = ppc; m_rpc[pid] = prpc; m_mask[pid] = pmask;
    end
    e.cnt = m_cnt;
    for (int k = 0; k < N; k++) e.ord[k*IDW +: IDW] = m_q[k][IDW-1:0];
    e.sp  = (m_cnt >= 2);
    e.sid = e.sp ? m_q[1] : NONE;
    e.sok = e.sp && m_v[e.sid] && !m_b[e.sid] && !m_x[e.sid];
    e.spc   = e.sok ? m_pc[e.sid]   : 32'h0;
    e.srpc  = e.sok ? m_rpc[e.sid]  : 32'h0;
    e.smask = e.sok ? m_mask[e.sid] : 32'h0;
    e.mvd = me; e.mvok = hit; e.act = m_act; e.uerr = uerr;
    e.lv    = (lid < N) && m_v[lid < N ? lid : 0];
    e.lpc   = e.lv ? m_pc[lid]   : 32'h0;
    e.lmask = e.lv ? m_mask[lid] : 32'h0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_push(input int id, input logic [31:0] pc, input logic [31:0] mask,
                         input bit b, input bit x, input string tag);
    step(1, id, pc, pc + 32'h40, mask, b, x, 0, 0, 0, 0, 0, id, tag);
  endtask

  task automatic do_move(input int id, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, id, 0, 0, 0, id, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    drive_idle();
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // monitor: compares one expected record just after each active edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk("R2", "q_count", 64'(q_count), 64'(e.cnt));
      chk(t, "q_order", 64'(q_order), 64'(e.ord));
      chk("R11", "q_order layout", 64'(q_order), 64'(e.ord));
      chk("R3", "sec_present", 64'(sec_present), 64'(e.sp));
      chk("R3", "sec_id", 64'(sec_id), 64'(e.sid));
      chk("R4", "sec_ok", 64'(sec_ok), 64'(e.sok));
      chk("R4", "sec_pc", 64'(sec_pc), 64'(e.spc));
      chk("R4", "sec_rpc", 64'(sec_rpc), 64'(e.srpc));
      chk("R4", "sec_mask", 64'(sec_mask), 64'(e.smask));
      chk(t, "mv_done", 64'(mv_done), 64'(e.mvd));
      chk(t, "mv_ok", 64'(mv_ok), 64'(e.mvok));
      chk(t, "active_id", 64'(active_id), 64'(e.act));
      chk("R8", "upd_err", 64'(upd_err), 64'(e.uerr));
      chk("R9", "look_valid", 64'(look_valid), 64'(e.lv));
      chk("R9", "look_pc", 64'(look_pc), 64'(e.lpc));
      chk("R9", "look_mask", 64'(look_mask), 64'(e.lmask));
    end
  end

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    drive_idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "q_count", 64'(q_count), 64'd0);
    chk("R1", "q_order", 64'(q_order), 64'hFFFF_FFFF);
    chk("R1", "active_id", 64'(active_id), 64'(NONE));
    chk("R1", "sec_present", 64'(sec_present), 64'd0);
    chk("R1", "mv_done", 64'(mv_done), 64'd0);
    chk("R1", "upd_err", 64'(upd_err), 64'd0);

    // R2 loads, duplicates and out-of-range IDs
    do_push(3, 32'h100, 32'h0000_00F0, 1, 0, "R2");
    do_push(5, 32'h110, 32'h0000_0F00, 0, 0, "R2");
    do_push(1, 32'h120, 32'h0000_F000, 0, 1, "R2");
    do_push(6, 32'h130, 32'h0000_000F, 0, 0, "R2");
    do_push(5, 32'h999, 32'hFFFF_FFFF, 0, 0, "R2");
    do_push(9, 32'h888, 32'h1, 0, 0, "R2");
    // R5 target already at the head
    do_move(3, "R5");
    // R7 target not queued
    do_move(2, "R7");
    // R6 tail to head, then a middle entry
    do_move(6, "R6");
    do_move(1, "R6");
    // R8 update on a live split, then on a free slot
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 32'h777, 6, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h555, 2, "R8");
    // R10 push and move in one cycle, then move naming the pushed ID
    step(1, 2, 32'h200, 32'h240, 32'h00F0_0000, 0, 0, 1, 5, 0, 0, 0, 2, "R10");
    step(1, 4, 32'h300, 32'h340, 32'h0F00_0000, 0, 0, 1, 4, 0, 0, 0, 4, "R10");
    do_push(0, 32'h400, 32'h1000_0000, 0, 0, "R2");
    do_push(7, 32'h500, 32'h2000_0000, 0, 0, "R2");
    do_push(7, 32'h600, 32'h3, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 7, 1, 7, 32'h7070, 7, "R6");

    // R7 move on an empty queue; R3 single entry has no secondary
    do_reset();
    do_move(0, "R7");
    do_push(2, 32'h20, 32'h3, 0, 0, "R3");
    do_move(2, "R5");

    // random mixes against the model
    for (int r = 0; r < 12; r++) begin
      do_reset();
      for (int s = 0; s < 60; s++) begin
        step($urandom_range(0, 2) != 0, $urandom_range(0, 9),
             $urandom(), $urandom(), $urandom(),
             $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 9),
             $urandom_range(0, 3) == 0, $urandom_range(0, 9), $urandom(),
             $urandom_range(0, 9), "R10");
      end
    end

    @(negedge clk);
    drive_idle();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule